// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target with Write Lock

This block is the digital side of a two-wire serial memory target that fronts a 1024-byte array. The bus clock and data lines are brought into a fast system clock through a synchronizer. Every protocol step is then decided on the system clock, using the rising and falling edges of the bus clock and the START and STOP conditions seen on the bus.

A transfer opens with a select byte. This byte carries a fixed device code, one chip-select bit that is compared against a strapped input, the two top address bits and the read/write flag. A write transfer then takes a word address and any number of data bytes. A read transfer returns bytes from an internal address counter until the host declines one. A repeated START after the word address turns a dummy write into a random read. A write-lock input freezes the array: the target still acknowledges both address phases but refuses every data byte.

The data line is modelled as an open-drain enable. Asserting `sda_oe` pulls the line low, and releasing it lets the pull-up win.

Top module: `i2c_ee_tgt`

## Requirements
- R1: The select byte is sent MSB first as 1010, chip-select, a9, a8, R/W. The target acknowledges it only when the upper four bits equal 1010 and the chip-select bit equals `csel_i`. On any mismatch it leaves SDA released for the rest of the transfer, until the next START.
- R2: A STOP condition returns the target to idle and releases SDA. An address already loaded by a word-address byte is kept for the next transfer.
- R3: The 10-bit address counter advances by one after each byte stored and after each byte sent, and wraps from 1023 to 0.
- R4: A START that arrives during a transfer (repeated START) restarts select-byte reception. A write select, a word address, then a repeated START with a read select returns the byte at {a9,a8,word}.
- R5: The target only ever pulls SDA low. It starts driving only while SCL is low. It samples incoming bits on the rising SCL edge.
- R6: With `wp_i` low, the target acknowledges (SDA low) the select byte, the word address and every data byte. Each data byte is stored at the current address {a9,a8,word}, then at the following addresses.
- R7: With `wp_i` high, the target acknowledges the select byte and the word address but releases SDA (NACK) on every data byte. The array and the address counter stay unchanged.
- R8: In a read, a host acknowledge (SDA low on the ninth clock) makes the target send the next byte. A host NACK ends the read and leaves SDA released.
- R9: A read select with no preceding word address (current-address read) starts at the address counter as left by the last transfer.
- R10: After reset, SDA is released and the address counter is 0. The array contents are not touched by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| wp_i | input | 1 | Write lock, high blocks array updates |
| csel_i | input | 1 | Strapped chip-select value compared with select bit 3 |
| sda_oe | output | 1 | High pulls SDA low, low releases it |

## Verification
The bench writes blocks that run past address 1023. A counter that failed to wrap, or one that picked up the top bits at the wrong moment, would read back bytes from the wrong rows. It sends a locked write and then does a current-address read. A design that advanced the counter on a refused byte, or that stored the byte anyway, would return the wrong data. A design that refused the address phases while locked would show a NACK where an ACK is expected. Select bytes with a wrong code or a wrong chip-select bit must draw no acknowledge. A STOP placed right after a word address checks that the loaded address survives. A second reset is followed by a read that must start at row 0 while the array keeps its contents.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DSEL,
      ST_DACK,
      ST_WADR,
      ST_AACK,
      ST_WDAT,
      ST_WACK,
      ST_RDAT,
      ST_RACK,
      ST_SKIP
   } ee_st_t;

   localparam logic [3:0] DEV_CODE = 4'b1010;
   localparam int         BYTE_W   = 8;
endpackage

// File: rtl/i2c_ee_front.sv
module i2c_ee_front #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_p, sda_p;
   logic              scl_d, sda_d;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_p[0] <= 1'b1;
                  sda_p[0] <= 1'b1;
               end else begin
                  scl_p[0] <= scl_i;
                  sda_p[0] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_p[g] <= 1'b1;
                  sda_p[g] <= 1'b1;
               end else begin
                  scl_p[g] <= scl_p[g-1];
                  sda_p[g] <= sda_p[g-1];
               end
            end
         end
      end
   endgenerate

   assign scl_s = scl_p[STAGES-1];
   assign sda_s = sda_p[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_ee_shift.sv
module i2c_ee_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         shift_en,
   input  logic         bit_in,
   output logic [W-1:0] byte_o,
   output logic         full
);
   localparam int CW = $clog2(W + 1);
   logic [CW-1:0] cnt;

   assign full = (cnt == CW'(W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         byte_o <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (shift_en && !full) begin
         byte_o <= {byte_o[W-2:0], bit_in};
         cnt    <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
   parameter int AW = 10,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;
   logic [DW-1:0] arr [DEPTH];

   always_ff @(posedge clk) begin
      if (we) arr[waddr] <= wdata;
   end

   assign rdata = arr[raddr];
endmodule

// File: rtl/i2c_ee_tgt.sv
module i2c_ee_tgt #(
   parameter int ADDR_W      = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic wp_i,
   input  logic csel_i,
   output logic sda_oe
);
   import i2c_ee_pkg::*;

   localparam int HI_W = ADDR_W - BYTE_W;

   generate
      if (HI_W != 2) begin : g_bad_aw
         $error("ADDR_W must be 10: the select byte carries two address bits");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [BYTE_W-1:0] rx_byte, rd_byte, tx;
   logic              rx_full, rx_shift, rx_clr;
   logic [ADDR_W-1:0] addr;
   logic [HI_W-1:0]   hi;
   logic              rw, mack;
   logic [2:0]        tcnt;
   logic              wr_en, addr_inc, addr_ld;
   ee_st_t            st;

   i2c_ee_front #(.STAGES(SYNC_STAGES)) u_front (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   assign rx_shift = scl_rise & ((st == ST_DSEL) | (st == ST_WADR) | (st == ST_WDAT));
   assign rx_clr   = start_det | stop_det | (scl_fall & rx_full);

   i2c_ee_shift #(.W(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr), .shift_en(rx_shift),
      .bit_in(sda_s), .byte_o(rx_byte), .full(rx_full)
   );

   i2c_ee_mem #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
      .clk(clk), .we(wr_en), .waddr(addr), .wdata(rx_byte),
      .raddr(addr), .rdata(rd_byte)
   );

   always_comb begin
      wr_en    = 1'b0;
      addr_inc = 1'b0;
      addr_ld  = 1'b0;
      if (!start_det && !stop_det && scl_fall) begin
         case (st)
            ST_WADR: addr_ld  = rx_full;
            ST_WDAT: begin
               wr_en    = rx_full & ~wp_i;
               addr_inc = rx_full & ~wp_i;
            end
            ST_RDAT: addr_inc = (tcnt == 3'd7);
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (addr_ld) begin
         addr <= {hi, rx_byte};
      end else if (addr_inc) begin
         addr <= addr + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         sda_oe <= 1'b0;
         hi     <= '0;
         rw     <= 1'b0;
         tx     <= '0;
         tcnt   <= '0;
         mack   <= 1'b0;
      end else if (stop_det) begin
         st     <= ST_IDLE;
         sda_oe <= 1'b0;
      end else if (start_det) begin
         st     <= ST_DSEL;
         sda_oe <= 1'b0;
      end else begin
         case (st)
            ST_DSEL: if (scl_fall && rx_full) begin
               if (rx_byte[7:4] == DEV_CODE && rx_byte[3] == csel_i) begin
                  sda_oe <= 1'b1;
                  rw     <= rx_byte[0];
                  if (!rx_byte[0]) hi <= rx_byte[2:1];
                  st     <= ST_DACK;
               end else begin
                  st <= ST_SKIP;
               end
            end
            ST_DACK: if (scl_fall) begin
               if (rw) begin
                  tx     <= rd_byte;
                  sda_oe <= ~rd_byte[7];
                  tcnt   <= '0;
                  st     <= ST_RDAT;
               end else begin
                  sda_oe <= 1'b0;
                  st     <= ST_WADR;
               end
            end
            ST_WADR: if (scl_fall && rx_full) begin
               sda_oe <= 1'b1;
               st     <= ST_AACK;
            end
            ST_AACK: if (scl_fall) begin
               sda_oe <= 1'b0;
               st     <= ST_WDAT;
            end
            ST_WDAT: if (scl_fall && rx_full) begin
               sda_oe <= ~wp_i;
               st     <= ST_WACK;
            end
            ST_WACK: if (scl_fall) begin
               sda_oe <= 1'b0;
               st     <= ST_WDAT;
            end
            ST_RDAT: if (scl_fall) begin
               if (tcnt == 3'd7) begin
                  sda_oe <= 1'b0;
                  st     <= ST_RACK;
               end else begin
                  sda_oe <= ~tx[6];
                  tx     <= {tx[6:0], 1'b0};
                  tcnt   <= tcnt + 1'b1;
               end
            end
            ST_RACK: begin
               if (scl_rise) mack <= ~sda_s;
               if (scl_fall) begin
                  if (mack) begin
                     tx     <= rd_byte;
                     sda_oe <= ~rd_byte[7];
                     tcnt   <= '0;
                     st     <= ST_RDAT;
                  end else begin
                     st <= ST_SKIP;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2c_ee_chk.sv
module i2c_ee_chk #(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              sda_oe,
   input logic              wr_en,
   input logic              wp_i,
   input logic [ADDR_W-1:0] addr,
   input logic              addr_inc,
   input logic              addr_ld,
   input logic              start_det,
   input logic              stop_det,
   input i2c_ee_pkg::ee_st_t st
);
   import i2c_ee_pkg::*;

   a_r5_drive_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   a_r7_locked_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !wp_i);

   a_r3_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
      addr_inc |=> addr == ADDR_W'($past(addr) + 1'b1));

   a_r3_counter_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_inc && !addr_ld) |=> $stable(addr));

   a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_oe && st == ST_IDLE));

   a_r4_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det && !stop_det) |=> (st == ST_DSEL && !sda_oe));
endmodule

bind i2c_ee_tgt i2c_ee_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
   .wr_en(wr_en), .wp_i(wp_i), .addr(addr), .addr_inc(addr_inc),
   .addr_ld(addr_ld), .start_det(start_det), .stop_det(stop_det), .st(st)
);

// File: tb/sim_i2c_ee_tgt.sv
module sim_i2c_ee_tgt;
   localparam int Q = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0, csel = 1'b0;
   logic sda_oe;
   wire  bus = sda_m & ~sda_oe;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;
   logic [7:0] model [1024];

   always #4 clk = ~clk;

   i2c_ee_tgt u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus),
      .wp_i(wp), .csel_i(csel), .sda_oe(sda_oe)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic b_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic b_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic send(input logic [7:0] b, output logic ack_line);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(Q);
         scl_m = 1'b1; tick(2*Q);
         scl_m = 1'b0;
      end
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      ack_line = bus; tick(Q);
      scl_m = 1'b0; tick(1);
   endtask

   task automatic recv(input bit host_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q);
         scl_m = 1'b1; tick(Q);
         b[i] = bus; tick(Q);
         scl_m = 1'b0;
      end
      tick(1);
      sda_m = ~host_ack; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(1);
      sda_m = 1'b1;
   endtask

   function automatic logic [7:0] sel(input logic cs, input logic [9:0] a, input logic rd);
      return {4'b1010, cs, a[9:8], rd};
   endfunction

   task automatic wr_blk(input int base, input int n, input int salt);
      logic a;
      logic [9:0] ad;
      logic [7:0] v;
      b_start();
      ad = 10'(base);
      send(sel(csel, ad, 1'b0), a); chk("R6 select ack", {7'd0, a}, 8'd0);
      send(ad[7:0], a);             chk("R6 word ack", {7'd0, a}, 8'd0);
      for (int i = 0; i < n; i++) begin
         ad = 10'(base + i);
         v  = 8'((base + i) * 29 + salt * 7 + 3);
         send(v, a); chk("R6 data ack", {7'd0, a}, 8'd0);
         model[ad] = v;
      end
      b_stop();
   endtask

   task automatic rd_rand(input int base, input int n);
      logic a;
      logic [9:0] ad;
      logic [7:0] v;
      ad = 10'(base);
      b_start();
      send(sel(csel, ad, 1'b0), a); chk("R4 select ack", {7'd0, a}, 8'd0);
      send(ad[7:0], a);             chk("R4 word ack", {7'd0, a}, 8'd0);
      b_start();
      send(sel(csel, ad, 1'b1), a); chk("R4 read select ack", {7'd0, a}, 8'd0);
      for (int i = 0; i < n; i++) begin
         recv(i < n - 1, v);
         chk("R8 R3 seq data", v, model[10'(base + i)]);
      end
      b_stop();
   endtask

   task automatic rd_cur(input int from, input int n, input string tag);
      logic a;
      logic [7:0] v;
      b_start();
      send(sel(csel, 10'd0, 1'b1), a); chk("R9 select ack", {7'd0, a}, 8'd0);
      for (int i = 0; i < n; i++) begin
         recv(i < n - 1, v);
         chk(tag, v, model[10'(from + i)]);
      end
      b_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic a;
      logic [7:0] v;
      tick(5);
      rst_n = 1'b1;
      tick(3);
      chk("R10 reset release", {7'd0, sda_oe}, 8'd0);

      // sweep of blocks, the first one runs past 1023 (R3 wrap)
      wr_blk(1008, 32, 1);
      wr_blk(0, 32, 2);
      wr_blk(300, 16, 3);
      wr_blk(700, 16, 4);
      wr_blk(511, 4, 5);
      rd_rand(1008, 32);
      rd_rand(0, 32);
      rd_rand(700, 16);
      rd_rand(511, 4);
      rd_rand(300, 8);
      rd_cur(308, 8, "R9 current read");

      // R7: locked writes
      wp = 1'b1;
      b_start();
      send(sel(csel, 10'd305, 1'b0), a); chk("R7 select ack", {7'd0, a}, 8'd0);
      send(8'd49, a);                   chk("R7 word ack", {7'd0, a}, 8'd0);
      send(8'h5A, a);                   chk("R7 data nack", {7'd0, a}, 8'd1);
      send(8'hA5, a);                   chk("R7 second nack", {7'd0, a}, 8'd1);
      b_stop();
      wp = 1'b0;
      rd_cur(305, 2, "R7 array and counter kept");

      // R1: mismatching select bytes
      b_start();
      send(8'hA8, a); chk("R1 wrong cs nack", {7'd0, a}, 8'd1);
      send(8'h00, a); chk("R1 ignored byte", {7'd0, a}, 8'd1);
      b_stop();
      b_start();
      send(8'hB0, a); chk("R1 wrong code nack", {7'd0, a}, 8'd1);
      b_stop();
      csel = 1'b1;
      wr_blk(600, 2, 6);
      rd_rand(600, 2);

      // R2: stop right after the word address keeps the loaded address
      b_start();
      send(sel(csel, 10'd320, 1'b0), a);
      send(8'd64, a);
      b_stop();
      tick(4);
      chk("R2 released after stop", {7'd0, sda_oe}, 8'd0);
      rd_cur(320, 1, "R2 address kept");

      // R10: second reset, counter back to 0, array kept
      rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(3);
      rd_cur(0, 3, "R10 counter zero");

      recv(1'b0, v); // clock with no transfer open: target must stay silent
      chk("R5 silent when idle", v, 8'hFF);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule